// File: doc/BRIEF.md
# External Trigger Qualifier

This block turns a raw, asynchronous trigger pin into a clean one-cycle start request for an analog conversion sequencer. The pin is first brought into the peripheral clock domain by a chain of flip-flops. A run-length history then records how long the synchronised level has held, and how long the level before the last transition held. A two-bit condition field selects the event type: a low or high level that must persist, or a falling or rising transition that must be clean on both sides.

A qualified event raises `startPulse` for one clock. The sequencer treats this pulse as it would a software write of its start bit. The qualifier responds only while external triggering is enabled and the sequencer mode field selects single-pass scan. After each pulse the block waits until the sequencer has gone busy and then returned to idle before it will fire again. A held level therefore produces one start per completed scan rather than a stream of starts.

Top module: `ext_trig_qualifier`

## Requirements
- R1: `trigCond` selects the event: 2'b00 low level, 2'b01 high level, 2'b10 falling transition, 2'b11 rising transition. An event of a different kind than the selected one produces no pulse.
- R2: For a level condition, the pin must hold the active level for 8 consecutive synchronised samples. With the block armed and its history at the opposite level, a pin change driven before clock edge 1 raises `startPulse` after edge 11.
- R3: For a transition condition, the old level must have held at least 4 synchronised samples and the new level must reach exactly 4 samples. With a long-held old level, a pin change driven before edge 1 raises `startPulse` after edge 7.
- R4: A transition is rejected if the level on either side of it lasts fewer than 4 samples, so short glitches and chatter produce no pulse.
- R5: A pulse can occur only when `trigEnable` is 1 and `seqMode` is 2'b10 (single-pass scan). With modes 2'b00, 2'b01 and 2'b11, or with `trigEnable` at 0, there is no pulse.
- R6: `startPulse` is high for exactly one clock per accepted trigger.
- R7: No pulse is issued while `seqBusy` is 1. After a pulse, the block re-arms only after `seqBusy` has been seen at 1 and then at 0, so a held level fires once per completed scan.
- R8: The run-length history restarts whenever qualification is lost, whether `trigEnable` drops or the mode leaves single-pass scan. Stability must then be rebuilt from zero.
- R9: While `rst_n` is 0, `startPulse` is 0, the history holds level 0 with zero counts, and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigPin | input | 1 | Raw asynchronous trigger pin |
| trigEnable | input | 1 | External trigger enable |
| trigCond | input | 2 | Event condition select (see R1) |
| seqMode | input | 2 | Sequencer operating mode; 2'b10 is single-pass scan |
| seqBusy | input | 1 | Sequencer is converting |
| startPulse | output | 1 | One-cycle start-set request to the sequencer |

## Verification
An error in the run-length history appears at `startPulse` as a pulse one or more cycles early or late, a missing pulse, or an extra pulse. Because the longest qualification window is 8 samples plus the synchroniser, any such error shows within about 11 clocks of the pin change that exposes it. An error in the arming state shows as a second pulse during a busy window, or as a held level that never fires again after the sequencer returns to idle. Comparing the output against a reference on every clock therefore localises each fault to the cycle where it first appears.

// File: rtl/trig_qual_pkg.sv
package trig_qual_pkg;

  typedef enum logic [1:0] {
    COND_LOW  = 2'b00,
    COND_HIGH = 2'b01,
    COND_FALL = 2'b10,
    COND_RISE = 2'b11
  } trig_cond_e;

  localparam logic [1:0] MODE_SCAN_ONCE = 2'b10;

  typedef enum logic [1:0] {
    ARM_READY     = 2'b00,
    ARM_WAIT_BUSY = 2'b01,
    ARM_WAIT_IDLE = 2'b10
  } arm_state_e;

  // control -> history strobes
  typedef struct packed {
    logic clearHist;
  } hist_ctl_t;

  // history -> control status
  typedef struct packed {
    logic curLvl;
    logic levelReady;
    logic edgeReady;
  } hist_stat_t;

endpackage

// File: rtl/trig_qual_hist.sv
module trig_qual_hist
  import trig_qual_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_MIN   = 8,
  parameter int EDGE_MIN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rawPin,
  input  hist_ctl_t  ctl,
  output hist_stat_t stat
);

  localparam int CNT_W = $clog2(LEVEL_MIN + 1);
  localparam logic [CNT_W-1:0] LVL_CNT = CNT_W'(LEVEL_MIN);
  localparam logic [CNT_W-1:0] EDG_CNT = CNT_W'(EDGE_MIN);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLvl;
  logic                   lastLvl;
  logic [CNT_W-1:0]       holdCnt;
  logic [CNT_W-1:0]       priorHold;

  // synchroniser: the stage count picks the form of the chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain <= '0;
        else        syncChain <= rawPin;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain <= '0;
        else        syncChain <= {syncChain[SYNC_STAGES-2:0], rawPin};
      end
    end
  endgenerate

  assign syncLvl = syncChain[SYNC_STAGES-1];

  // run-length history of the synchronised level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastLvl   <= 1'b0;
      holdCnt   <= '0;
      priorHold <= '0;
    end else if (ctl.clearHist) begin
      lastLvl   <= syncLvl;
      holdCnt   <= '0;
      priorHold <= '0;
    end else if (syncLvl != lastLvl) begin
      lastLvl   <= syncLvl;
      priorHold <= holdCnt;
      holdCnt   <= ONE_CNT;
    end else if (holdCnt != LVL_CNT) begin
      holdCnt   <= holdCnt + ONE_CNT;
    end
  end

  always_comb begin
    stat.curLvl     = lastLvl;
    stat.levelReady = (holdCnt == LVL_CNT);
    stat.edgeReady  = (holdCnt == EDG_CNT) && (priorHold >= EDG_CNT);
  end

  // counters saturate at the level window and never run past it
  assert_hold_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (holdCnt <= LVL_CNT) && (priorHold <= LVL_CNT));

  // a fresh run after a transition always starts at one sample
  assert_run_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.clearHist && $past(ctl.clearHist) == 1'b0 && lastLvl != $past(lastLvl)) |-> holdCnt == ONE_CNT);

endmodule

// File: rtl/trig_qual_ctl.sv
module trig_qual_ctl
  import trig_qual_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trigEnable,
  input  logic [1:0] trigCond,
  input  logic [1:0] seqMode,
  input  logic       seqBusy,
  input  hist_stat_t stat,
  output hist_ctl_t  ctl,
  output logic       startPulse
);

  arm_state_e armState;
  logic       qualified;
  logic       condHit;
  logic       fireNow;

  assign qualified = trigEnable && (seqMode == MODE_SCAN_ONCE);

  always_comb begin
    ctl.clearHist = !qualified;
  end

  always_comb begin
    case (trig_cond_e'(trigCond))
      COND_LOW:  condHit = stat.levelReady && !stat.curLvl;
      COND_HIGH: condHit = stat.levelReady &&  stat.curLvl;
      COND_FALL: condHit = stat.edgeReady  && !stat.curLvl;
      default:   condHit = stat.edgeReady  &&  stat.curLvl;
    endcase
  end

  assign fireNow = qualified && (armState == ARM_READY) && !seqBusy && condHit;

  // arming: fire, wait for busy, wait for idle, re-arm
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armState <= ARM_READY;
    end else if (!qualified) begin
      armState <= ARM_READY;
    end else begin
      case (armState)
        ARM_READY:     if (fireNow) armState <= ARM_WAIT_BUSY;
        ARM_WAIT_BUSY: if (seqBusy) armState <= ARM_WAIT_IDLE;
        ARM_WAIT_IDLE: if (!seqBusy) armState <= ARM_READY;
        default:       armState <= ARM_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) startPulse <= 1'b0;
    else        startPulse <= fireNow;
  end

  assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);

  assert_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> ($past(trigEnable) && $past(seqMode) == MODE_SCAN_ONCE));

  assert_level_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (startPulse && !$past(trigCond[1])) |->
      ($past(stat.levelReady) && $past(stat.curLvl) == $past(trigCond[0])));

  assert_edge_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (startPulse && $past(trigCond[1])) |->
      ($past(stat.edgeReady) && $past(stat.curLvl) == $past(trigCond[0])));

  assert_idle_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> !$past(seqBusy));

endmodule

// File: rtl/ext_trig_qualifier.sv
module ext_trig_qualifier
  import trig_qual_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_MIN   = 8,
  parameter int EDGE_MIN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trigPin,
  input  logic       trigEnable,
  input  logic [1:0] trigCond,
  input  logic [1:0] seqMode,
  input  logic       seqBusy,
  output logic       startPulse
);

  hist_ctl_t  histCtl;
  hist_stat_t histStat;

  trig_qual_hist #(
    .SYNC_STAGES(SYNC_STAGES),
    .LEVEL_MIN  (LEVEL_MIN),
    .EDGE_MIN   (EDGE_MIN)
  ) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .rawPin(trigPin),
    .ctl   (histCtl),
    .stat  (histStat)
  );

  trig_qual_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trigEnable(trigEnable),
    .trigCond  (trigCond),
    .seqMode   (seqMode),
    .seqBusy   (seqBusy),
    .stat      (histStat),
    .ctl       (histCtl),
    .startPulse(startPulse)
  );

endmodule

// File: tb/ext_trig_qualifier_bench.sv
`timescale 1ns/1ps
module ext_trig_qualifier_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trigPin = 1'b0;
  logic       trigEnable = 1'b0;
  logic [1:0] trigCond = 2'b01;
  logic [1:0] seqMode = 2'b10;
  logic       seqBusy = 1'b0;
  logic       startPulse;

  always #10 clk = ~clk;

  ext_trig_qualifier u_ext_trig_qualifier (
    .clk(clk), .rst_n(rst_n), .trigPin(trigPin), .trigEnable(trigEnable),
    .trigCond(trigCond), .seqMode(seqMode), .seqBusy(seqBusy),
    .startPulse(startPulse)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  int    pulseCnt = 0;
  int    firstPulseCyc = -1;
  int    busyCnt = 0;
  bit    compareOn = 0;
  bit    finished = 0;
  string phaseTag = "R9";

  // behavioural reference state
  bit    pinQ[$];
  bit    mLvl;
  int    mRun;
  int    mPrev;
  int    mArm;       // 0 ready, 1 waiting for busy, 2 waiting for idle
  bit    mPulse;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      pinQ = '{0, 0};
      mLvl = 0; mRun = 0; mPrev = 0; mArm = 0; mPulse = 0;
    end else begin
      bit qual, hit, fire, syn;
      qual = trigEnable && (seqMode == 2'b10);
      if (!trigCond[1]) hit = (mRun >= 8) && (mLvl == trigCond[0]);
      else              hit = (mRun == 4) && (mPrev >= 4) && (mLvl == trigCond[0]);
      fire = qual && (mArm == 0) && !seqBusy && hit;
      mPulse = fire;
      if (!qual) mArm = 0;
      else if (mArm == 0 && fire) mArm = 1;
      else if (mArm == 1 && seqBusy) mArm = 2;
      else if (mArm == 2 && !seqBusy) mArm = 0;
      syn = pinQ[0];
      if (!qual) begin
        mRun = 0; mPrev = 0; mLvl = syn;
      end else if (syn != mLvl) begin
        mPrev = mRun; mRun = 1; mLvl = syn;
      end else if (mRun < 8) begin
        mRun++;
      end
      void'(pinQ.pop_front());
      pinQ.push_back(trigPin);
    end
  end

  // per-cycle comparison, pulse bookkeeping and a small sequencer stand-in
  always @(negedge clk) begin
    if (compareOn && rst_n && !finished) begin
      check(startPulse === mPulse, phaseTag, startPulse, mPulse);
      if (startPulse) begin
        pulseCnt++;
        if (firstPulseCyc < 0) firstPulseCyc = cyc;
      end
    end
    if (startPulse) busyCnt = 4;
    else if (busyCnt > 0) busyCnt--;
    seqBusy = (busyCnt > 0);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic prep(input logic [1:0] cond, input logic pin);
    trigEnable = 1'b0;
    seqMode = 2'b10;
    trigCond = cond;
    trigPin = pin;
    tick(8);
    trigEnable = 1'b1;
    tick(12);
    pulseCnt = 0;
    firstPulseCyc = -1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int mark;
    tick(4);
    check(startPulse === 1'b0, "R9 reset output", startPulse, 0);
    rst_n = 1'b1;
    compareOn = 1;
    tick(2);
    check(startPulse === 1'b0, "R9 after reset, disabled", startPulse, 0);

    // R2: high level latency, then R7 re-arm on a held level
    phaseTag = "R2 high level";
    prep(2'b01, 1'b0);
    mark = cyc; trigPin = 1'b1;
    tick(14);
    check(firstPulseCyc - mark == 11, "R2 level latency", firstPulseCyc - mark, 11);
    check(pulseCnt == 1, "R2 single pulse", pulseCnt, 1);
    phaseTag = "R7 held level re-arm";
    tick(30);
    check(pulseCnt >= 2, "R7 re-arm after idle", pulseCnt, 2);

    // R1: low level condition
    phaseTag = "R1 low level";
    prep(2'b00, 1'b1);
    check(pulseCnt == 0, "R1 low level idle at high", pulseCnt, 0);
    mark = cyc; trigPin = 1'b0;
    tick(13);
    check(firstPulseCyc - mark == 11, "R1 low level latency", firstPulseCyc - mark, 11);

    // R3: rising edge
    phaseTag = "R3 rising";
    prep(2'b11, 1'b0);
    mark = cyc; trigPin = 1'b1;
    tick(12);
    check(firstPulseCyc - mark == 7, "R3 rising latency", firstPulseCyc - mark, 7);
    trigPin = 1'b0;
    tick(14);
    check(pulseCnt == 1, "R1 falling ignored under rising", pulseCnt, 1);

    // R3: falling edge
    phaseTag = "R3 falling";
    prep(2'b10, 1'b1);
    mark = cyc; trigPin = 1'b0;
    tick(12);
    check(firstPulseCyc - mark == 7, "R3 falling latency", firstPulseCyc - mark, 7);
    check(pulseCnt == 1, "R3 falling count", pulseCnt, 1);

    // R4: short high glitch, then short low before a long high
    phaseTag = "R4 glitch";
    prep(2'b11, 1'b0);
    trigPin = 1'b1; tick(2);
    trigPin = 1'b0; tick(12);
    check(pulseCnt == 0, "R4 short high rejected", pulseCnt, 0);
    trigPin = 1'b1; tick(2);
    trigPin = 1'b0; tick(2);
    trigPin = 1'b1; tick(14);
    check(pulseCnt == 0, "R4 short low before edge rejected", pulseCnt, 0);

    // R5: mode and enable gating
    phaseTag = "R5 gating";
    prep(2'b01, 1'b0);
    seqMode = 2'b01; trigPin = 1'b1; tick(20);
    check(pulseCnt == 0, "R5 burst mode ignored", pulseCnt, 0);
    seqMode = 2'b11; tick(20);
    check(pulseCnt == 0, "R5 continuous mode ignored", pulseCnt, 0);
    seqMode = 2'b00; tick(20);
    check(pulseCnt == 0, "R5 single mode ignored", pulseCnt, 0);
    seqMode = 2'b10; trigEnable = 1'b0; tick(20);
    check(pulseCnt == 0, "R5 enable low ignored", pulseCnt, 0);

    // R8: losing qualification restarts the history
    phaseTag = "R8 restart";
    trigCond = 2'b01; trigPin = 1'b1; trigEnable = 1'b0;
    tick(8);
    trigEnable = 1'b1; tick(5);
    trigEnable = 1'b0; tick(1);
    trigEnable = 1'b1;
    pulseCnt = 0;
    tick(8);
    check(pulseCnt == 0, "R8 no early pulse after restart", pulseCnt, 0);
    tick(4);
    check(pulseCnt == 1, "R8 pulse after full window", pulseCnt, 1);

    tick(4);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

endmodule